// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial configuration port for a display receiver. It is a two-wire bus target with a fixed 7-bit device address and a bank of 32 byte-wide registers. The serial clock and data lines are sampled with the system clock. The data line is driven as open drain: the block only ever pulls it low, through a drive-low enable. A bus master uses single-byte transfers to read the identification constants and to program the control registers. The control registers are presented to the rest of the chip as parallel outputs, and the timing-control register is also decoded into named fields.

A write sends the device address with the direction bit clear, then a register index, then one data byte. A read can take one of two forms. In the first, the master sets the index in a write-direction phase, issues a repeated start and then addresses the device for reading. In the second, the master addresses the device for reading straight away and gets the register that the index pointer already holds. Once one read has been served, the next read is refused until a write-direction address phase has taken place.

Top module: `tws_regbank`

## Requirements
- R1: Straight after reset the block leaves the data line undriven (sda_oe = 0), all ten control bytes are 00h, setup_hold_sel = 0, stagger_n = 0, and the index pointer holds 0.
- R2: The block acknowledges only the device address 7'b0111110, which is bus byte 7Ch for a write and 7Dh for a read. For any other address it does not pull the data line low on any bit until the next start condition.
- R3: A write (start, 7Ch, index, data, stop) gets an acknowledge on each of its three bytes. When the index is in 20..29, the data appears on ctrl_regs[(index-20)*8 +: 8].
- R4: An addressed read (start, 7Ch, index, repeated start, 7Dh, data, master ack/nack, stop) is acknowledged and returns the register contents most significant bit first. The block changes its drive only while the clock is low.
- R5: The read-only identity registers return 05h, 13h, 28h, 67h, 00h, 08h and 87h at indices 0 to 6.
- R6: A read that begins directly with 7Dh returns the register at the index latched by the last write-direction transaction.
- R7: After a served read, a following read that begins directly with 7Dh is not acknowledged. Any write-direction address phase clears this refusal.
- R8: Writes to indices outside 20..29 are acknowledged and have no effect. Reads of indices 7..19, 30 and 31, and of indices of 32 and above, return 00h.
- R9: Register 29 drives setup_hold_sel from bit[2:1] and stagger_n from bit[0].
- R10: Only one data byte is taken per write. A second data byte before the stop is not acknowledged and is not stored. A stop condition returns the block to idle with the data line released.
- R11: After a read byte the block accepts either an ACK or a NACK from the master and releases the line in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| ctrl_regs | output | 80 | Control bytes, index 20 in bits [7:0] through index 29 in bits [79:72] |
| setup_hold_sel | output | 2 | Output setup/hold offset code from register 29 |
| stagger_n | output | 1 | Active-low output stagger control from register 29 |

## Verification
The bench targets several corner cases. One is a second current-address read straight after a served one: a design that ignores the refusal rule would acknowledge it and drive data. Another is a write aimed at a read-only or absent index: a wrong decode would either corrupt a control byte or withhold the acknowledge. A further data byte inside a write is also sent, and a design that auto-increments would store it at the next index. The bench also sends a foreign device address, after which any acknowledge shows that the address compare is broken. Finally it ends a read with a master ACK instead of a NACK, which would expose a design that keeps the line held after the byte.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam logic [6:0] TWS_DEV_ADDR    = 7'b0111110;
    localparam int         TWS_REG_COUNT   = 32;
    localparam int         TWS_RW_BASE     = 20;
    localparam int         TWS_RW_COUNT    = 10;
    localparam int         TWS_SYNC_STAGES = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_WAIT
    } tws_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic [7:0] id_byte(input logic [7:0] idx);
        logic [7:0] v;
        case (idx)
            8'd0:    v = 8'h05;
            8'd1:    v = 8'h13;
            8'd2:    v = 8'h28;
            8'd3:    v = 8'h67;
            8'd4:    v = 8'h00;
            8'd5:    v = 8'h08;
            8'd6:    v = 8'h87;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tws_linesync.sv
module tws_linesync
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = TWS_SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_prev;
    logic                   sda_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_sh[SYNC_STAGES-1];
            sda_prev <= sda_sh[SYNC_STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_sh[SYNC_STAGES-1];
        ev.sda      = sda_sh[SYNC_STAGES-1];
        ev.scl_rise = ev.scl && !scl_prev;
        ev.scl_fall = !ev.scl && scl_prev;
        ev.start    = ev.scl && scl_prev && sda_prev && !ev.sda;
        ev.stop     = ev.scl && scl_prev && !sda_prev && ev.sda;
    end

endmodule

// File: rtl/tws_regfile.sv
module tws_regfile
    import tws_pkg::*;
#(
    parameter int REG_COUNT = TWS_REG_COUNT,
    parameter int RW_BASE   = TWS_RW_BASE,
    parameter int RW_COUNT  = TWS_RW_COUNT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    input  logic [7:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic [RW_COUNT*8-1:0] ctrl_flat
);
    generate
        for (genvar g = 0; g < RW_COUNT; g++) begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr.en && wr.addr == 8'(RW_BASE + g))
                    q <= wr.data;
            end
            assign ctrl_flat[g*8 +: 8] = q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_addr < 8'(REG_COUNT))
            rd_data = id_byte(rd_addr);
        for (int i = 0; i < RW_COUNT; i++) begin
            if (rd_addr == 8'(RW_BASE + i))
                rd_data = ctrl_flat[i*8 +: 8];
        end
    end

endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
    import tws_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = TWS_DEV_ADDR
) (
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output wr_req_t    wr,
    output logic       sda_oe
);
    tws_state_e state;
    logic [2:0] cnt;
    logic [7:0] shreg;
    logic [7:0] shift_nxt;
    logic       ack_ph;
    logic       rw;
    logic       lock;

    assign shift_nxt = {shreg[6:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            ack_ph <= 1'b0;
            rw     <= 1'b0;
            lock   <= 1'b0;
            ptr    <= '0;
            wr     <= '0;
            sda_oe <= 1'b0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                ack_ph <= 1'b0;
            end else if (ev.start) begin
                state  <= ST_DEV;
                cnt    <= '0;
                sda_oe <= 1'b0;
                ack_ph <= 1'b0;
            end else begin
                case (state)
                    ST_DEV: if (ev.scl_rise) begin
                        shreg <= shift_nxt;
                        cnt   <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            if (shift_nxt[7:1] == DEV_ADDR && !(shift_nxt[0] && lock)) begin
                                state <= ST_DEV_ACK;
                                rw    <= shift_nxt[0];
                                if (!shift_nxt[0])
                                    lock <= 1'b0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_DEV_ACK: if (ev.scl_fall) begin
                        if (!ack_ph) begin
                            ack_ph <= 1'b1;
                            sda_oe <= 1'b1;
                        end else begin
                            ack_ph <= 1'b0;
                            cnt    <= '0;
                            if (rw) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_REG;
                            end
                        end
                    end
                    ST_REG: if (ev.scl_rise) begin
                        shreg <= shift_nxt;
                        cnt   <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            ptr   <= shift_nxt;
                            state <= ST_REG_ACK;
                        end
                    end
                    ST_REG_ACK: if (ev.scl_fall) begin
                        if (!ack_ph) begin
                            ack_ph <= 1'b1;
                            sda_oe <= 1'b1;
                        end else begin
                            ack_ph <= 1'b0;
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WR;
                        end
                    end
                    ST_WR: if (ev.scl_rise) begin
                        shreg <= shift_nxt;
                        cnt   <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            wr.en   <= 1'b1;
                            wr.addr <= ptr;
                            wr.data <= shift_nxt;
                            state   <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: if (ev.scl_fall) begin
                        if (!ack_ph) begin
                            ack_ph <= 1'b1;
                            sda_oe <= 1'b1;
                        end else begin
                            ack_ph <= 1'b0;
                            sda_oe <= 1'b0;
                            state  <= ST_WAIT;
                        end
                    end
                    ST_RD: if (ev.scl_fall) begin
                        if (cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RD_ACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            cnt    <= cnt + 3'd1;
                        end
                    end
                    ST_RD_ACK: if (ev.scl_rise) begin
                        lock  <= 1'b1;
                        state <= ST_WAIT;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tws_regbank.sv
module tws_regbank
    import tws_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = TWS_DEV_ADDR,
    parameter int         REG_COUNT   = TWS_REG_COUNT,
    parameter int         RW_BASE     = TWS_RW_BASE,
    parameter int         RW_COUNT    = TWS_RW_COUNT,
    parameter int         SYNC_STAGES = TWS_SYNC_STAGES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [RW_COUNT*8-1:0] ctrl_regs,
    output logic [1:0]            setup_hold_sel,
    output logic                  stagger_n
);
    localparam int TIMING_SLOT = RW_COUNT - 1;

    line_ev_t   line_ev;
    wr_req_t    wr_req;
    logic [7:0] ptr;
    logic [7:0] rd_data;

    tws_linesync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (line_ev)
    );

    tws_fsm #(.DEV_ADDR(DEV_ADDR)) fsm_i (
        .clk     (clk),
        .rst     (rst),
        .ev      (line_ev),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr      (wr_req),
        .sda_oe  (sda_oe)
    );

    tws_regfile #(
        .REG_COUNT (REG_COUNT),
        .RW_BASE   (RW_BASE),
        .RW_COUNT  (RW_COUNT)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_req),
        .rd_addr   (ptr),
        .rd_data   (rd_data),
        .ctrl_flat (ctrl_regs)
    );

    assign setup_hold_sel = ctrl_regs[TIMING_SLOT*8+1 +: 2];
    assign stagger_n      = ctrl_regs[TIMING_SLOT*8];

endmodule

// File: rtl/tws_regbank_chk.sv
module tws_regbank_chk #(
    parameter int RW_BASE  = 20,
    parameter int RW_COUNT = 10
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sda_oe,
    input logic [RW_COUNT*8-1:0] ctrl_regs,
    input logic [1:0]            setup_hold_sel,
    input logic                  stagger_n,
    input logic                  scl_lvl,
    input logic                  stop_seen,
    input logic                  wr_en,
    input logic [7:0]            wr_addr,
    input logic [7:0]            wr_data
);
    localparam logic [7:0] TIMING_IDX = 8'(RW_BASE + RW_COUNT - 1);
    localparam logic [7:0] RW_LO      = 8'(RW_BASE);
    localparam logic [7:0] RW_HI      = 8'(RW_BASE + RW_COUNT);

    assert_drive_on_low_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_lvl));

    assert_ro_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_regs) |-> ($past(wr_en) && $past(wr_addr) >= RW_LO && $past(wr_addr) < RW_HI));

    assert_timing_fields_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == TIMING_IDX) |=>
            (stagger_n == $past(wr_data[0]) && setup_hold_sel == $past(wr_data[2:1])));

    assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_oe);

endmodule

bind tws_regbank tws_regbank_chk #(
    .RW_BASE  (RW_BASE),
    .RW_COUNT (RW_COUNT)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .sda_oe         (sda_oe),
    .ctrl_regs      (ctrl_regs),
    .setup_hold_sel (setup_hold_sel),
    .stagger_n      (stagger_n),
    .scl_lvl        (line_ev.scl),
    .stop_seen      (line_ev.stop),
    .wr_en          (wr_req.en),
    .wr_addr        (wr_req.addr),
    .wr_data        (wr_req.data)
);

// File: tb/tws_regbank_tb_top.sv
module tws_regbank_tb_top;
    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [79:0] ctrl_regs;
    logic [1:0]  setup_hold_sel;
    logic        stagger_n;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    logic [7:0] shadow [32];
    logic [7:0] m_ptr = 8'd0;
    bit         m_lock = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    tws_regbank dut_i (
        .clk            (clk),
        .rst            (rst),
        .scl_i          (m_scl),
        .sda_i          (sda_line),
        .sda_oe         (sda_oe),
        .ctrl_regs      (ctrl_regs),
        .setup_hold_sel (setup_hold_sel),
        .stagger_n      (stagger_n)
    );

    function automatic logic [7:0] exp_val(input logic [7:0] idx);
        logic [7:0] v;
        v = 8'h00;
        if (idx >= 8'd20 && idx <= 8'd29) v = shadow[idx[4:0]];
        else case (idx)
            8'd0: v = 8'h05;
            8'd1: v = 8'h13;
            8'd2: v = 8'h28;
            8'd3: v = 8'h67;
            8'd5: v = 8'h08;
            8'd6: v = 8'h87;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [79:0] exp_ctrl();
        logic [79:0] v;
        for (int i = 0; i < 10; i++) v[i*8 +: 8] = shadow[20+i];
        return v;
    endfunction

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; hold(Q);
        m_sda = 1'b0; hold(Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_sda = 1'b0; hold(Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_sda = 1'b1; hold(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; hold(Q);
        m_scl = 1'b1; hold(2*Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; hold(Q);
        m_scl = 1'b1; hold(Q);
        b = sda_line; hold(Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic xfer(input logic [7:0] b, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        send_bit(!master_ack);
    endtask

    task automatic wr_txn(input logic [7:0] idx, input logic [7:0] data, output logic ok);
        logic a0, a1, a2;
        a1 = 1'b0; a2 = 1'b0;
        bus_start();
        xfer(8'h7C, a0);
        if (a0) begin
            xfer(idx, a1);
            xfer(data, a2);
        end
        bus_stop();
        ok = a0 && a1 && a2;
        if (ok) begin
            m_ptr = idx; m_lock = 1'b0;
            if (idx >= 8'd20 && idx <= 8'd29) shadow[idx[4:0]] = data;
        end
    endtask

    task automatic rd_txn(input logic [7:0] idx, input logic master_ack,
                          output logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        a1 = 1'b0; a2 = 1'b0; d = 8'hxx;
        bus_start();
        xfer(8'h7C, a0);
        if (a0) begin
            xfer(idx, a1);
            bus_rstart();
            xfer(8'h7D, a2);
            if (a2) read_byte(master_ack, d);
        end
        bus_stop();
        ok = a0 && a1 && a2;
        if (a0) begin m_ptr = idx; m_lock = 1'b0; end
        if (ok) m_lock = 1'b1;
    endtask

    task automatic rd_cur(output logic [7:0] d, output logic ok);
        logic a0;
        d = 8'h00;
        bus_start();
        xfer(8'h7D, a0);
        if (a0) read_byte(1'b0, d);
        bus_stop();
        ok = a0;
        if (ok) m_lock = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic       ok, a, b;
        logic [7:0] d;
        logic [7:0] idx, val;
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) shadow[i] = 8'h00;
        hold(5);
        rst = 1'b0;
        hold(2);

        // R1: reset state
        chk("R1 sda_oe", 80'(sda_oe), 80'd0);
        chk("R1 ctrl", ctrl_regs, 80'd0);
        chk("R1 fields", 80'({setup_hold_sel, stagger_n}), 80'd0);
        rd_cur(d, ok);
        chk("R1 pointer zero", 80'({ok, d}), 80'({1'b1, 8'h05}));
        m_lock = 1'b1;

        // R2: foreign device address, then a further byte
        bus_start();
        xfer(8'h7E, a);
        chk("R2 foreign addr nack", 80'(a), 80'd0);
        xfer(8'h00, b);
        chk("R2 silent after mismatch", 80'(b), 80'd0);
        bus_stop();
        chk("R2 released", 80'(sda_oe), 80'd0);

        // R5, R8: identity and empty indices
        for (int i = 0; i < 12; i++) begin
            rd_txn(8'(i), 1'b0, d, ok);
            chk(i < 7 ? "R5 id read" : "R8 empty read", 80'({ok, d}), 80'({1'b1, exp_val(8'(i))}));
        end
        rd_txn(8'd31, 1'b0, d, ok);
        chk("R8 index 31", 80'({ok, d}), 80'({1'b1, 8'h00}));
        rd_txn(8'h45, 1'b0, d, ok);
        chk("R8 out of range", 80'({ok, d}), 80'({1'b1, 8'h00}));

        // R9: timing register fields
        wr_txn(8'd29, 8'h05, ok);
        chk("R9 write ack", 80'(ok), 80'd1);
        chk("R9 fields a", 80'({setup_hold_sel, stagger_n}), 80'({2'b10, 1'b1}));
        wr_txn(8'd29, 8'h02, ok);
        chk("R9 fields b", 80'({setup_hold_sel, stagger_n}), 80'({2'b01, 1'b0}));

        // R8: writes to read-only and empty indices
        wr_txn(8'd3, 8'hAA, ok);
        chk("R8 ro write acked", 80'(ok), 80'd1);
        rd_txn(8'd3, 1'b0, d, ok);
        chk("R8 ro unchanged", 80'(d), 80'h67);
        wr_txn(8'd15, 8'h55, ok);
        rd_txn(8'd15, 1'b0, d, ok);
        chk("R8 empty unchanged", 80'(d), 80'h00);
        chk("R8 ctrl intact", ctrl_regs, exp_ctrl());

        // R6, R7: current-address reads and refusal
        wr_txn(8'd22, 8'h3C, ok);
        rd_cur(d, ok);
        chk("R6 current read", 80'({ok, d}), 80'({1'b1, 8'h3C}));
        rd_cur(d, ok);
        chk("R7 second read refused", 80'(ok), 80'd0);
        rd_cur(d, ok);
        chk("R7 still refused", 80'(ok), 80'd0);
        wr_txn(8'd22, 8'hC3, ok);
        rd_cur(d, ok);
        chk("R7 served after write", 80'({ok, d}), 80'({1'b1, 8'hC3}));

        // R10: one data byte per write
        bus_start();
        xfer(8'h7C, a);
        xfer(8'd24, a);
        xfer(8'h11, a);
        chk("R10 first data acked", 80'(a), 80'd1);
        xfer(8'h22, b);
        chk("R10 second data nack", 80'(b), 80'd0);
        bus_stop();
        shadow[24] = 8'h11;
        m_ptr = 8'd24; m_lock = 1'b0;
        chk("R10 no burst store", ctrl_regs, exp_ctrl());
        chk("R10 idle release", 80'(sda_oe), 80'd0);

        // R11: master ACK after read byte
        rd_txn(8'd24, 1'b1, d, ok);
        chk("R11 read with ack", 80'({ok, d}), 80'({1'b1, 8'h11}));
        chk("R11 released", 80'(sda_oe), 80'd0);
        wr_txn(8'd25, 8'h9A, ok);
        chk("R11 next write", 80'(ok), 80'd1);

        // R3, R4: random traffic
        for (int n = 0; n < 30; n++) begin
            idx = 8'(20 + ($urandom % 10));
            val = 8'($urandom);
            wr_txn(idx, val, ok);
            chk("R3 write acked", 80'(ok), 80'd1);
            chk("R3 ctrl image", ctrl_regs, exp_ctrl());
            idx = 8'($urandom % 32);
            rd_txn(idx, n[0], d, ok);
            chk("R4 addressed read", 80'({ok, d}), 80'({1'b1, exp_val(idx)}));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule